// File: doc/BRIEF.md
# Core-to-Mesh Flit Packetizer

This block sits between a processing core and its mesh router. On the send side it takes 64-bit words from the core and groups them into fixed-length packets. Each packet is one header flit that carries the destination coordinates, followed by four data flits. The first three data flits are marked as body flits and the fourth as the tail. Every network flit is 66 bits wide: a 2-bit type tag sits above the 64-bit payload.

On the receive side the block takes 66-bit flits from the router and removes the tag. It drops the header and passes the data payloads to the core as 64-bit words. It also checks that the incoming flits arrive in the order header, body, body, body, tail.

All four data paths use a valid/ready handshake, and a word moves in a cycle only when valid and ready are both high. A source that raises valid must keep it high, with its data unchanged, until the word is accepted. Back-pressure passes through with no buffering. A stalled router stalls the core's send channel, and a core that is not ready stalls the router's delivery of data flits. The error output is a plain one-cycle pulse.

Top module: `noc_core_adapter`

## Requirements
- R1: A network flit has its type in bits [65:64] and its payload in bits [63:0]. The type codes are 01 for header, 10 for body and 11 for tail. Code 00 means idle and is never driven while `net_tx_valid` is high.
- R2: Each transmitted packet is a header flit followed by exactly four data flits of type body, body, body and tail. The data payloads are the core words in the order they were accepted, and the flit after a tail is always a header.
- R3: The header payload holds the destination X in bits [7:4] and Y in bits [3:0], with all other payload bits zero. Both fields are taken from `dest_x`/`dest_y` in the cycle the header is accepted. Changing the destination while the data flits are being sent has no effect on the packet in progress.
- R4: A header is offered only while the core presents a word (`core_tx_valid` high). `core_tx_ready` stays low while the header is pending.
- R5: During the data flits, `core_tx_ready` equals `net_tx_ready`. No core word is lost or duplicated when the router stalls.
- R6: On receive, a flit of the expected header type is accepted with `net_rx_ready` high regardless of `core_rx_ready`. It is never delivered to the core.
- R7: A received flit of the expected body or tail type is delivered with `core_rx_data` equal to bits [63:0]. `core_rx_valid` follows `net_rx_valid` and `net_rx_ready` follows `core_rx_ready`.
- R8: A received flit whose type differs from the expected one, including 00, is consumed and not delivered. `rx_err` is high for exactly the cycle after it is accepted. If the bad flit is a header, the next flit is expected to be a body flit; otherwise the next flit is expected to be a header.
- R9: While reset (`rst_n` low) is applied, `net_tx_valid`, `core_rx_valid` and `rx_err` are low when the inputs are idle. After reset, both sides expect a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dest_x | input | 4 | Destination X coordinate for the next header |
| dest_y | input | 4 | Destination Y coordinate for the next header |
| core_tx_data | input | 64 | Word from the core to send |
| core_tx_valid | input | 1 | Core word is present |
| core_tx_ready | output | 1 | Core word is accepted this cycle if valid |
| net_tx_flit | output | 66 | Flit to the router |
| net_tx_valid | output | 1 | Flit to the router is present |
| net_tx_ready | input | 1 | Router accepts the flit |
| net_rx_flit | input | 66 | Flit from the router |
| net_rx_valid | input | 1 | Flit from the router is present |
| net_rx_ready | output | 1 | Flit from the router is consumed this cycle if valid |
| core_rx_data | output | 64 | Payload delivered to the core |
| core_rx_valid | output | 1 | Delivered payload is present |
| core_rx_ready | input | 1 | Core accepts the payload |
| rx_err | output | 1 | Pulse one cycle after an out-of-order flit was consumed |

## Verification
The assertions check the following on every cycle:
- an idle code is never sent while valid is high;
- the flit after a tail is a header, and any other flit is not;
- a core word is only taken through a data flit;
- a header is never delivered to the core;
- receive back-pressure is passed to the router;
- an error pulse always follows an accepted flit.

Only the bench scenarios can show the rest:
- that payloads arrive intact and in order under random stalls;
- that the header carries the destination present when it was accepted, while later destination changes are ignored;
- that the receive side resynchronizes correctly after each kind of misordered flit.

// File: rtl/nca_pkg.sv
package nca_pkg;
  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_type_e;
endpackage

// File: rtl/nca_tx_framer.sv
module nca_tx_framer
  import nca_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int COORD_W    = 4,
  parameter int DATA_FLITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COORD_W-1:0]  dest_x,
  input  logic [COORD_W-1:0]  dest_y,
  input  logic [DATA_W-1:0]   core_tx_data,
  input  logic                core_tx_valid,
  output logic                core_tx_ready,
  output logic [DATA_W+1:0]   net_tx_flit,
  output logic                net_tx_valid,
  input  logic                net_tx_ready
);
  localparam int SLOT_W = $clog2(DATA_FLITS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_FLITS);

  logic [SLOT_W-1:0] slot_q;
  logic              is_head;
  flit_type_e        cur_type;
  logic [DATA_W-1:0] hdr_payload;
  logic              step;

  always_comb begin
    is_head  = (slot_q == '0);
    cur_type = is_head ? FT_HEAD : ((slot_q == LAST_SLOT) ? FT_TAIL : FT_BODY);
    hdr_payload = '0;
    hdr_payload[2*COORD_W-1:0] = {dest_x, dest_y};
    net_tx_valid  = core_tx_valid;
    net_tx_flit   = {cur_type, (is_head ? hdr_payload : core_tx_data)};
    core_tx_ready = !is_head && net_tx_ready;
    step          = net_tx_valid && net_tx_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      slot_q <= '0;
    else if (step)
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
  end

  // Independent record of whether the last accepted flit closed a packet
  logic prev_tail_q;
  always_ff @(posedge clk) begin
    if (!rst_n)
      prev_tail_q <= 1'b1;
    else if (step)
      prev_tail_q <= (net_tx_flit[DATA_W+1:DATA_W] == FT_TAIL);
  end

  AST_TX_NO_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid |-> net_tx_flit[DATA_W+1:DATA_W] != FT_IDLE); // R1
  AST_TX_HEAD_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && prev_tail_q) |-> net_tx_flit[DATA_W+1:DATA_W] == FT_HEAD); // R2
  AST_TX_NO_HEAD_MIDPACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prev_tail_q) |-> net_tx_flit[DATA_W+1:DATA_W] != FT_HEAD); // R2
  AST_TX_WORD_IN_DATA_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tx_valid && core_tx_ready) |->
      (step && net_tx_flit[DATA_W+1:DATA_W] != FT_HEAD)); // R4
endmodule

// File: rtl/nca_rx_deframer.sv
module nca_rx_deframer
  import nca_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DATA_FLITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W+1:0]  net_rx_flit,
  input  logic               net_rx_valid,
  output logic               net_rx_ready,
  output logic [DATA_W-1:0]  core_rx_data,
  output logic               core_rx_valid,
  input  logic               core_rx_ready,
  output logic               rx_err
);
  localparam int SLOT_W = $clog2(DATA_FLITS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_FLITS);

  logic [SLOT_W-1:0] slot_q;
  flit_type_e        exp_type;
  logic [1:0]        rx_type;
  logic              match, deliver, take;
  logic              rx_err_q;

  always_comb begin
    exp_type = (slot_q == '0) ? FT_HEAD :
               ((slot_q == LAST_SLOT) ? FT_TAIL : FT_BODY);
    rx_type  = net_rx_flit[DATA_W+1:DATA_W];
    match    = (rx_type == exp_type);
    deliver  = match && (slot_q != '0);
    core_rx_valid = net_rx_valid && deliver;
    core_rx_data  = net_rx_flit[DATA_W-1:0];
    net_rx_ready  = deliver ? core_rx_ready : 1'b1;
    take          = net_rx_valid && net_rx_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      rx_err_q <= 1'b0;
    end else begin
      rx_err_q <= take && !match;
      if (take) begin
        if (match)
          slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        else
          slot_q <= (rx_type == FT_HEAD) ? SLOT_W'(1) : '0;
      end
    end
  end

  assign rx_err = rx_err_q;

  AST_RX_HEAD_NOT_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    core_rx_valid |-> net_rx_flit[DATA_W+1:DATA_W] != FT_HEAD); // R6
  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_valid && !core_rx_ready) |-> !net_rx_ready); // R7
  AST_RX_ERR_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> $past(net_rx_valid && net_rx_ready)); // R8
  AST_RX_IDLE_NEVER_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (net_rx_valid && rx_type == FT_IDLE) |-> (!core_rx_valid && net_rx_ready)); // R8
endmodule

// File: rtl/noc_core_adapter.sv
module noc_core_adapter #(
  parameter int DATA_W     = 64,
  parameter int COORD_W    = 4,
  parameter int DATA_FLITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COORD_W-1:0]  dest_x,
  input  logic [COORD_W-1:0]  dest_y,
  input  logic [DATA_W-1:0]   core_tx_data,
  input  logic                core_tx_valid,
  output logic                core_tx_ready,
  output logic [DATA_W+1:0]   net_tx_flit,
  output logic                net_tx_valid,
  input  logic                net_tx_ready,
  input  logic [DATA_W+1:0]   net_rx_flit,
  input  logic                net_rx_valid,
  output logic                net_rx_ready,
  output logic [DATA_W-1:0]   core_rx_data,
  output logic                core_rx_valid,
  input  logic                core_rx_ready,
  output logic                rx_err
);
  nca_tx_framer #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .DATA_FLITS(DATA_FLITS)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .dest_x(dest_x), .dest_y(dest_y),
    .core_tx_data(core_tx_data), .core_tx_valid(core_tx_valid),
    .core_tx_ready(core_tx_ready),
    .net_tx_flit(net_tx_flit), .net_tx_valid(net_tx_valid),
    .net_tx_ready(net_tx_ready)
  );

  nca_rx_deframer #(
    .DATA_W(DATA_W), .DATA_FLITS(DATA_FLITS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .net_rx_flit(net_rx_flit), .net_rx_valid(net_rx_valid),
    .net_rx_ready(net_rx_ready),
    .core_rx_data(core_rx_data), .core_rx_valid(core_rx_valid),
    .core_rx_ready(core_rx_ready), .rx_err(rx_err)
  );
endmodule

// File: tb/test_noc_core_adapter.sv
module test_noc_core_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int NPKT       = 8;
  localparam int NWORD      = NPKT * 4;
  localparam int RX_MAX     = 64;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  dest_x, dest_y;
  logic [63:0] core_tx_data;
  logic        core_tx_valid, core_tx_ready;
  logic [65:0] net_tx_flit;
  logic        net_tx_valid, net_tx_ready;
  logic [65:0] net_rx_flit;
  logic        net_rx_valid, net_rx_ready;
  logic [63:0] core_rx_data;
  logic        core_rx_valid, core_rx_ready;
  logic        rx_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  noc_core_adapter i_noc_core_adapter (
    .clk(clk), .rst_n(rst_n), .dest_x(dest_x), .dest_y(dest_y),
    .core_tx_data(core_tx_data), .core_tx_valid(core_tx_valid),
    .core_tx_ready(core_tx_ready), .net_tx_flit(net_tx_flit),
    .net_tx_valid(net_tx_valid), .net_tx_ready(net_tx_ready),
    .net_rx_flit(net_rx_flit), .net_rx_valid(net_rx_valid),
    .net_rx_ready(net_rx_ready), .core_rx_data(core_rx_data),
    .core_rx_valid(core_rx_valid), .core_rx_ready(core_rx_ready),
    .rx_err(rx_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] tx_words [NWORD];
  logic [3:0]  tx_dx [NPKT];
  logic [3:0]  tx_dy [NPKT];
  logic [65:0] rx_list [RX_MAX];
  int          rx_len = 0;

  task automatic chk(input bit ok, input string req, input logic [65:0] act,
                     input logic [65:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_type(input int s);
    if (s == 0) return 2'b01;
    if (s == 4) return 2'b11;
    return 2'b10;
  endfunction

  function automatic logic [65:0] hdr_flit(input logic [3:0] x, input logic [3:0] y);
    return {2'b01, 56'd0, x, y};
  endfunction

  task automatic rx_push(input logic [1:0] t, input logic [63:0] p);
    rx_list[rx_len] = {t, p};
    rx_len++;
  endtask

  task automatic rx_good_pkt();
    rx_push(2'b01, {32'd0, $urandom});
    rx_push(2'b10, {$urandom, $urandom});
    rx_push(2'b10, {$urandom, $urandom});
    rx_push(2'b10, {$urandom, $urandom});
    rx_push(2'b11, {$urandom, $urandom});
  endtask

  initial begin
    int cyc = 0;
    int tx_wi = 0, tx_pkt = 0, tx_s = 0;
    int rx_i = 0, rx_s = 0;
    bit tx_took = 0, rx_took = 0, err_exp = 0;
    logic [65:0] exp_f;
    bit match;

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NWORD; i++) tx_words[i] = {$urandom, $urandom};
    for (int p = 0; p < NPKT; p++) begin
      tx_dx[p] = 4'($urandom);
      tx_dy[p] = 4'($urandom);
    end
    tx_dx[0] = 4'hF; tx_dy[0] = 4'h0;
    // receive stream: good packets, then each kind of misordering
    rx_good_pkt(); rx_good_pkt(); rx_good_pkt();
    rx_push(2'b10, 64'hDEAD);                       // body when header expected
    rx_good_pkt();
    rx_push(2'b01, 64'h1); rx_push(2'b10, 64'h2); rx_push(2'b10, 64'h3);
    rx_push(2'b01, 64'h4);                          // header mid-packet
    rx_push(2'b10, 64'h5); rx_push(2'b10, 64'h6); rx_push(2'b10, 64'h7);
    rx_push(2'b11, 64'h8);
    rx_push(2'b01, 64'h9); rx_push(2'b00, 64'hA);   // idle code mid-packet
    rx_push(2'b11, 64'hB);                          // tail when header expected
    rx_good_pkt(); rx_good_pkt();

    rst_n = 1'b0;
    dest_x = '0; dest_y = '0; core_tx_data = '0; core_tx_valid = 1'b0;
    net_tx_ready = 1'b0; net_rx_flit = '0; net_rx_valid = 1'b0;
    core_rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(net_tx_valid == 1'b0, "R9 tx valid in reset", 66'(net_tx_valid), 66'd0);
    chk(core_rx_valid == 1'b0, "R9 rx valid in reset", 66'(core_rx_valid), 66'd0);
    chk(rx_err == 1'b0, "R9 err in reset", 66'(rx_err), 66'd0);
    @(negedge clk);
    rst_n = 1'b1;

    while (!(tx_pkt == NPKT && rx_i == rx_len) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      // ---- drive transmit side
      if (tx_took) begin core_tx_valid = 1'b0; tx_wi++; end
      if (!core_tx_valid && tx_wi < NWORD && ($urandom % 4 != 0)) begin
        core_tx_valid = 1'b1;
        core_tx_data  = tx_words[tx_wi];
      end
      if (tx_pkt < NPKT && tx_s == 0) begin
        dest_x = tx_dx[tx_pkt]; dest_y = tx_dy[tx_pkt];
      end else begin
        dest_x = 4'($urandom); dest_y = 4'($urandom); // R3: must be ignored
      end
      net_tx_ready = (cyc < 30) ? 1'b1 : ($urandom % 3 != 0);
      // ---- drive receive side
      if (rx_took) begin net_rx_valid = 1'b0; rx_i++; end
      if (!net_rx_valid && rx_i < rx_len && ($urandom % 4 != 0)) begin
        net_rx_valid = 1'b1;
        net_rx_flit  = rx_list[rx_i];
      end
      core_rx_ready = (cyc < 30) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      // ---- transmit checks
      tx_took = 0;
      if (tx_s == 0 && !core_tx_valid)
        chk(net_tx_valid == 1'b0, "R4 no header without word", 66'(net_tx_valid), 66'd0);
      if (net_tx_valid) begin
        exp_f = (tx_s == 0) ? hdr_flit(tx_dx[tx_pkt], tx_dy[tx_pkt])
                            : {exp_type(tx_s), tx_words[tx_pkt*4 + tx_s - 1]};
        chk(net_tx_flit == exp_f, (tx_s == 0) ? "R3 header payload" : "R2 R1 data flit",
            net_tx_flit, exp_f);
        if (tx_s == 0)
          chk(core_tx_ready == 1'b0, "R4 core stalled on header", 66'(core_tx_ready), 66'd0);
        else
          chk(core_tx_ready == net_tx_ready, "R5 ready passthrough",
              66'(core_tx_ready), 66'(net_tx_ready));
        if (net_tx_ready) begin
          tx_took = (tx_s != 0);
          if (tx_s == 4) begin tx_s = 0; tx_pkt++; end else tx_s++;
        end
      end
      // ---- receive checks
      chk(rx_err == err_exp, "R8 error pulse", 66'(rx_err), 66'(err_exp));
      err_exp = 0;
      rx_took = 0;
      if (net_rx_valid) begin
        match = (net_rx_flit[65:64] == exp_type(rx_s));
        if (!match) begin
          chk(!core_rx_valid && net_rx_ready, "R8 bad flit dropped",
              {core_rx_valid, net_rx_ready}, 66'b01);
        end else if (rx_s == 0) begin
          chk(!core_rx_valid && net_rx_ready, "R6 header consumed",
              {core_rx_valid, net_rx_ready}, 66'b01);
        end else begin
          chk(core_rx_valid && core_rx_data == net_rx_flit[63:0], "R7 payload delivered",
              {1'b0, core_rx_valid, core_rx_data}, {2'b01, net_rx_flit[63:0]});
          chk(net_rx_ready == core_rx_ready, "R7 rx backpressure",
              66'(net_rx_ready), 66'(core_rx_ready));
        end
        if (net_rx_ready) begin
          rx_took = 1;
          if (match) rx_s = (rx_s == 4) ? 0 : rx_s + 1;
          else begin
            err_exp = 1;
            rx_s = (net_rx_flit[65:64] == 2'b01) ? 1 : 0;
          end
        end
      end else begin
        chk(core_rx_valid == 1'b0, "R7 no valid without flit", 66'(core_rx_valid), 66'd0);
      end
    end

    @(negedge clk);
    #1;
    chk(rx_err == err_exp, "R8 final error pulse", 66'(rx_err), 66'(err_exp));
    if (cyc >= LIMIT) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired tx_pkt=%0d rx_i=%0d", tx_pkt, rx_i);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule